// File: doc/BRIEF.md
# 4-Bit Adaptive Delta PCM Decoder

The block turns a stream of 4-bit adaptive delta codes into signed 16-bit audio samples. Each code carries a sign and a 3-bit magnitude. The code moves the running sample up or down by a fraction of the current step size. The step size then grows or shrinks by a fixed factor chosen by the magnitude. Codes arrive packed two to a byte. The address parity of the sample picks the nibble, so the caller can present the same memory byte twice.

The caller drives one byte and an address bit per code, qualified by a valid strobe. The decoded sample appears one clock later with a one-cycle valid pulse, so one code can be decoded every clock. Between codes the output holds the last sample. The decoder state can be returned to its start values in two ways. A direct clear does it at any time. A loop-wrap strobe does it only when the voice is not in streaming mode.

Top module: `adpcm_nib_dec`

## Requirements
- R1: Code bit 3 is the sign (1 = subtract) and bits 2:0 are the magnitude d. The next sample is the previous sample plus or minus floor(step × (2d+1) / 8).
- R2: After each code the step becomes floor(step × m / 256), where m is 230 for d = 0..3 and 307, 409, 512, 614 for d = 4..7. A code with d below 4 never raises the step.
- R3: After each update the step is clamped to the range 127 to 24576.
- R4: The decoded sample saturates to the range -32768 to 32767.
- R5: With addr_lsb_i = 0 the code is byte_i[3:0]. With addr_lsb_i = 1 the code is byte_i[7:4].
- R6: After async reset, or after clr_i without code_vld_i, the state is step 127 and sample 0. In that case sample_o reads 0 and sample_vld_o is 0.
- R7: loop_wrap_i resets the decoder state as clr_i does while stream_i = 0. It has no effect while stream_i = 1.
- R8: sample_o and sample_vld_o update on the clock edge after the code_vld_i cycle. Without code_vld_i, sample_vld_o is 0 and sample_o holds its value, unless the state is being reset.
- R9: If a reset request and code_vld_i occur in the same cycle, the code is decoded from the reset state (step 127, sample 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous decoder state reset request |
| loop_wrap_i | input | 1 | Playback wrapped to the loop start |
| stream_i | input | 1 | Streaming mode; suppresses reset on wrap |
| code_vld_i | input | 1 | A code is presented this cycle |
| byte_i | input | 8 | Memory byte holding two codes |
| addr_lsb_i | input | 1 | Sample address parity, selects nibble |
| sample_o | output | 16 | Decoded signed sample |
| sample_vld_o | output | 1 | One-cycle pulse, new sample available |

## Verification
Several properties are checked by assertions on every cycle:
- The step register stays inside its clamp window.
- The valid pulse follows the code strobe by exactly one cycle.
- A positive code never lowers the sample, and a small-magnitude code never raises the step.
- A reset request without a code leaves a zero sample and the minimum step.

Exact arithmetic, the adaptation table, the nibble order and the streaming-versus-wrap distinction can only be shown by the bench. It compares each decoded sample against an independent model over random and directed code sequences. It also confirms that both sample rails and both step bounds were reached.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
  localparam int SAMPLE_W = 16;
  localparam int STEP_W   = 15;
  localparam int MULT_W   = 10;
  localparam int STEP_MIN = 127;
  localparam int STEP_MAX = 24576;

  // adaptation factor in 1/256 units, indexed by magnitude
  function automatic logic [MULT_W-1:0] step_mult(input logic [2:0] mag);
    case (mag)
      3'd4:    return MULT_W'(307);
      3'd5:    return MULT_W'(409);
      3'd6:    return MULT_W'(512);
      3'd7:    return MULT_W'(614);
      default: return MULT_W'(230);
    endcase
  endfunction
endpackage

// File: rtl/adpcm_nib_sel.sv
module adpcm_nib_sel #(
  parameter bit LOW_FIRST = 1'b1
) (
  input  logic [7:0] byte_i,
  input  logic       addr_lsb_i,
  output logic [3:0] code_o
);
  generate
    if (LOW_FIRST) begin : g_low_first
      assign code_o = addr_lsb_i ? byte_i[7:4] : byte_i[3:0];
    end else begin : g_high_first
      assign code_o = addr_lsb_i ? byte_i[3:0] : byte_i[7:4];
    end
  endgenerate
endmodule

// File: rtl/adpcm_step_adapt.sv
module adpcm_step_adapt
  import adpcm_pkg::*;
#(
  parameter int STEP_W_P   = STEP_W,
  parameter int STEP_MIN_P = STEP_MIN,
  parameter int STEP_MAX_P = STEP_MAX
) (
  input  logic [STEP_W_P-1:0] step_i,
  input  logic [2:0]          mag_i,
  output logic [STEP_W_P-1:0] step_o
);
  localparam int PW = STEP_W_P + MULT_W;
  localparam logic [PW-1:0] LIM_HI = PW'(STEP_MAX_P);
  localparam logic [PW-1:0] LIM_LO = PW'(STEP_MIN_P);

  logic [PW-1:0] prod, scaled;

  always_comb begin
    prod   = PW'(step_i) * PW'(step_mult(mag_i));
    scaled = prod >> 8;
    if (scaled > LIM_HI)      step_o = STEP_W_P'(STEP_MAX_P);
    else if (scaled < LIM_LO) step_o = STEP_W_P'(STEP_MIN_P);
    else                      step_o = scaled[STEP_W_P-1:0];
  end
endmodule

// File: rtl/adpcm_predict.sv
module adpcm_predict
  import adpcm_pkg::*;
#(
  parameter int SAMPLE_W_P = SAMPLE_W,
  parameter int STEP_W_P   = STEP_W
) (
  input  logic [SAMPLE_W_P-1:0] prev_i,
  input  logic [STEP_W_P-1:0]   step_i,
  input  logic [3:0]            code_i,
  output logic [SAMPLE_W_P-1:0] sample_o
);
  localparam int PW    = STEP_W_P + 4;
  localparam int DW    = STEP_W_P + 1;
  localparam int SUM_W = ((SAMPLE_W_P > DW) ? SAMPLE_W_P : DW) + 2;
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((2 ** (SAMPLE_W_P - 1)) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = -SUM_W'(2 ** (SAMPLE_W_P - 1));

  logic [PW-1:0]           prod;
  logic [DW-1:0]           delta;
  logic signed [SUM_W-1:0] prev_x, delta_x, sum;

  always_comb begin
    prod    = PW'(step_i) * PW'({code_i[2:0], 1'b1});
    delta   = prod[PW-1:3];
    prev_x  = {{(SUM_W-SAMPLE_W_P){prev_i[SAMPLE_W_P-1]}}, prev_i};
    delta_x = {{(SUM_W-DW){1'b0}}, delta};
    sum     = code_i[3] ? (prev_x - delta_x) : (prev_x + delta_x);
    if (sum > S_MAX)      sample_o = S_MAX[SAMPLE_W_P-1:0];
    else if (sum < S_MIN) sample_o = S_MIN[SAMPLE_W_P-1:0];
    else                  sample_o = sum[SAMPLE_W_P-1:0];
  end
endmodule

// File: rtl/adpcm_nib_dec.sv
module adpcm_nib_dec
  import adpcm_pkg::*;
#(
  parameter int SAMPLE_W_P = SAMPLE_W,
  parameter int STEP_W_P   = STEP_W,
  parameter int STEP_MIN_P = STEP_MIN,
  parameter int STEP_MAX_P = STEP_MAX,
  parameter bit LOW_FIRST  = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  loop_wrap_i,
  input  logic                  stream_i,
  input  logic                  code_vld_i,
  input  logic [7:0]            byte_i,
  input  logic                  addr_lsb_i,
  output logic [SAMPLE_W_P-1:0] sample_o,
  output logic                  sample_vld_o
);
  localparam logic [STEP_W_P-1:0] STEP_INIT = STEP_W_P'(STEP_MIN_P);

  logic [3:0]            code;
  logic                  rst_req;
  logic [STEP_W_P-1:0]   step_q, base_step, step_nxt;
  logic [SAMPLE_W_P-1:0] smp_q, base_smp, smp_nxt;
  logic                  vld_q;

  adpcm_nib_sel #(.LOW_FIRST(LOW_FIRST)) u_sel (
    .byte_i(byte_i), .addr_lsb_i(addr_lsb_i), .code_o(code)
  );

  // reset request takes effect before a coincident code
  assign rst_req   = clr_i | (loop_wrap_i & ~stream_i);
  assign base_step = rst_req ? STEP_INIT : step_q;
  assign base_smp  = rst_req ? '0 : smp_q;

  adpcm_predict #(.SAMPLE_W_P(SAMPLE_W_P), .STEP_W_P(STEP_W_P)) u_pred (
    .prev_i(base_smp), .step_i(base_step), .code_i(code), .sample_o(smp_nxt)
  );

  adpcm_step_adapt #(.STEP_W_P(STEP_W_P), .STEP_MIN_P(STEP_MIN_P),
                     .STEP_MAX_P(STEP_MAX_P)) u_step (
    .step_i(base_step), .mag_i(code[2:0]), .step_o(step_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STEP_INIT;
      smp_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= code_vld_i;
      if (code_vld_i) begin
        step_q <= step_nxt;
        smp_q  <= smp_nxt;
      end else if (rst_req) begin
        step_q <= STEP_INIT;
        smp_q  <= '0;
      end
    end
  end

  assign sample_o     = smp_q;
  assign sample_vld_o = vld_q;

  a_r3_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q >= STEP_W_P'(STEP_MIN_P)) && (step_q <= STEP_W_P'(STEP_MAX_P)));

  a_r8_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_i |=> sample_vld_o);

  a_r8_no_spurious_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_vld_i |=> !sample_vld_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!code_vld_i && !rst_req) |=> $stable(sample_o));

  a_r6_clear_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req && !code_vld_i) |=> (sample_o == '0 && step_q == STEP_INIT));

  a_r1_positive_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_vld_i && !rst_req && !code[3]) |=> ($signed(sample_o) >= $signed($past(sample_o))));

  a_r2_small_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_vld_i && !rst_req && !code[2]) |=> (step_q <= $past(step_q)));
endmodule

// File: tb/tb_adpcm_nib_dec.sv
module tb_adpcm_nib_dec;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, wrap = 1'b0, strm = 1'b0, vld = 1'b0, lsb = 1'b0;
  logic [7:0] byt = '0;
  logic [15:0] smp;
  logic        svld;

  int n_chk = 0, n_bad = 0;
  int m_prev = 0, m_step = 127;
  int hit_smax = 0, hit_smin = 0, hit_stmax = 0, hit_stmin = 0;
  int exp_q[$];
  int mult[8] = '{230, 230, 230, 230, 307, 409, 512, 614};
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  adpcm_nib_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .loop_wrap_i(wrap),
    .stream_i(strm), .code_vld_i(vld), .byte_i(byt), .addr_lsb_i(lsb),
    .sample_o(smp), .sample_vld_o(svld)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // driver: applies one cycle of stimulus and updates the model
  task automatic issue(input logic [7:0] b, input logic a, input logic v,
                       input logic c, input logic w, input logic s);
    int code, d, delta, ns, st;
    @(negedge clk);
    byt = b; lsb = a; vld = v; clr = c; wrap = w; strm = s;
    if (c || (w && !s)) begin m_prev = 0; m_step = 127; end
    if (v) begin
      code  = a ? int'(b[7:4]) : int'(b[3:0]);   // R5
      d     = code & 7;
      delta = (m_step * (2*d + 1)) >>> 3;        // R1
      ns    = (code & 8) ? m_prev - delta : m_prev + delta;
      if (ns > 32767)  begin ns = 32767;  hit_smax++; end   // R4
      if (ns < -32768) begin ns = -32768; hit_smin++; end
      st = (m_step * mult[d]) >>> 8;             // R2
      if (st > 24576) begin st = 24576; hit_stmax++; end    // R3
      if (st < 127)   begin st = 127;   hit_stmin++; end
      m_prev = ns; m_step = st;
      exp_q.push_back(ns);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: compares results after each active edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (svld) begin
        if (exp_q.size() == 0) check("R8 unexpected valid", 1, 0);
        else check("R1/R2/R5 sample", int'($signed(smp)), exp_q.pop_front());
      end else begin
        check("R8/R6 hold", int'($signed(smp)), m_prev);
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset sample", int'(smp), 0);
    check("R6 reset valid", int'(svld), 0);
    rst_n = 1'b1;
    idle(2);
    // R5: same byte, both parities
    issue(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R4/R3: drive to positive rail and step max
    for (int i = 0; i < 40; i++) issue(8'h77, i[0], 1'b1, 1'b0, 1'b0, 1'b0);
    // R4: negative rail
    for (int i = 0; i < 20; i++) issue(8'hFF, i[0], 1'b1, 1'b0, 1'b0, 1'b0);
    // R3: shrink to step min
    for (int i = 0; i < 60; i++) issue(8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(3);
    // R6: clear alone
    for (int i = 0; i < 5; i++) issue(8'h66, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(1);
    // R9: clear with code
    for (int i = 0; i < 5; i++) issue(8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(8'h07, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7: wrap in streaming mode keeps state, non-streaming resets it
    for (int i = 0; i < 5; i++) issue(8'h46, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    issue(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    issue(8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) issue(8'h65, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(1);
    // random sequences with gaps and occasional resets
    for (int i = 0; i < 4000; i++) begin
      automatic int r = $urandom_range(0, 99);
      issue(8'($urandom), 1'($urandom), (r < 80), (r == 99), (r == 98), 1'($urandom));
    end
    idle(4);
    done = 1'b1;
    check("R8 queue drained", exp_q.size(), 0);
    check("R4 positive rail reached", int'(hit_smax > 0), 1);
    check("R4 negative rail reached", int'(hit_smin > 0), 1);
    check("R3 step max reached", int'(hit_stmax > 0), 1);
    check("R3 step min reached", int'(hit_stmin > 0), 1);
    summary();
  end
endmodule